// File: doc/BRIEF.md
# Calendar Clock with Staged Register Writes

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day, month, year offset, leap flag) on a small 32-bit memory-mapped register bus. A one-clock pulse on `sec_tick` arrives once per second and advances the time. When the hours wrap past 23, the day advances. Month lengths follow the calendar, and February gets a 29th day only when the software-maintained leap flag is set. When December ends, the month returns to 1 and the year offset counts up.

Software sets the clock by writing the time word or the date word. A write does not land at once. It is held in a staging register for `COMMIT_CYCLES` clock cycles, as if it were crossing into a slow domain. During that time a per-register busy bit in the control word stays high, and reads return the old value. A second write to a register that is still pending restarts its wait with the newest data. The parameter `WIDE_YEAR` selects how the year is stored. With the default of 0, the year is a 6-bit offset (base 2010) with the leap flag at bit 22. With 1, the year is an 8-bit offset (base 1970) with the leap flag at bit 24.

Reads are registered. `bus_rdata` shows the register addressed in the previous cycle, as it stood before that clock edge.

Top module: `cal_clock`

## Requirements
- R1: After reset, the control word reads 0, the time word reads 0, and the date word reads 0x0000_0101 (day 1, month 1, year offset 0, leap 0).
- R2: A write to the time word (byte offset 0x08: seconds [5:0], minutes [13:8], hours [20:16]) sets control bit 8 from the next cycle. The bit stays set for exactly `COMMIT_CYCLES` cycles and then clears, and at that moment the written value becomes current.
- R3: A write to the date word (byte offset 0x04: day [4:0], month [11:8], year offset at [16 +: 6], leap flag at bit 22) behaves the same way on control bit 7. Control is byte offset 0x00.
- R4: While a register's write is pending, reading that register returns its previous value.
- R5: A write to a register whose commit is pending restarts the full `COMMIT_CYCLES` wait with the newest data. The older data is never applied.
- R6: Back-to-back writes (zero to time, then zero to date, then new values to each) are all accepted. Each write opens its own busy period, and the last value written to each register is the one that lands.
- R7: On each tick, seconds step and wrap at 59. A seconds wrap steps the minutes, which wrap at 59. A minutes wrap steps the hours, which wrap at 23.
- R8: When the hours wrap, the day steps. The last day of the month is 30 for April, June, September and November, 31 for the other months, and 28 for February, or 29 when the leap flag is set. After the last day, the day returns to 1 and the month steps.
- R9: After 31 December, the date becomes 1 January and the year offset steps, wrapping at its field width. The leap flag is not changed by rollover.
- R10: With `WIDE_YEAR`=1, the year offset is 8 bits at [23:16] and the leap flag is at bit 24. Both hold and roll over like the default layout.
- R11: Writes to the control word or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
The bench goes after the edges of the busy window. It checks the cycle just before the commit, where a design that is off by one would already show the new value or a cleared bit. It also checks a rewrite during a pending commit, where a design that lets the first commit through would briefly expose the stale data. The calendar table covers February in both leap states, a 30-day month, and the year wrap at its field width. A design with a wrong month table, or one that clears the leap flag on rollover, would land on the wrong day or flag. A second instance in the wide layout shows that the year and leap bits move to the right positions.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_DATE = 4;
  localparam int OFS_TIME = 8;

  localparam int CTRL_TIME_BUSY = 8;
  localparam int CTRL_DATE_BUSY = 7;

  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HR_LSB   = 16;
  localparam int DAY_LSB  = 0;
  localparam int MON_LSB  = 8;
  localparam int YEAR_LSB = 16;

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                     days_in_month = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  days_in_month = 5'd30;
      default:                  days_in_month = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_commit_stage.sv
module cal_commit_stage #(
  parameter int W     = 32,
  parameter int DELAY = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data,
  output logic         busy,
  output logic         commit
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] count;

  // A write in the final cycle replaces the commit with a restart.
  assign commit = (count == ONE) && !wr;
  assign busy   = (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      data  <= '0;
    end else if (wr) begin
      count <= LOAD;
      data  <= wdata;
    end else if (count != '0) begin
      count <= count - ONE;
    end
  end

  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    wr |=> busy);
  a_r5_restart_full_wait: assert property (@(posedge clk) disable iff (rst)
    wr |=> (count == LOAD) && (data == $past(wdata)));
  a_r2_clear_after_commit: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);
  a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(data));
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic [5:0] load_sec,
  input  logic [5:0] load_min,
  input  logic [4:0] load_hr,
  output logic [5:0] sec,
  output logic [5:0] min,
  output logic [4:0] hr,
  output logic       day_carry
);
  logic sec_wrap, min_wrap, hr_wrap, adv;

  assign sec_wrap  = (sec >= 6'd59);
  assign min_wrap  = (min >= 6'd59);
  assign hr_wrap   = (hr  >= 5'd23);
  assign adv       = tick && !load;
  assign day_carry = adv && sec_wrap && min_wrap && hr_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec <= '0;
      min <= '0;
      hr  <= '0;
    end else if (load) begin
      sec <= load_sec;
      min <= load_min;
      hr  <= load_hr;
    end else if (tick) begin
      if (!sec_wrap) begin
        sec <= sec + 6'd1;
      end else begin
        sec <= '0;
        if (!min_wrap) begin
          min <= min + 6'd1;
        end else begin
          min <= '0;
          hr  <= hr_wrap ? 5'd0 : hr + 5'd1;
        end
      end
    end
  end

  a_r7_sec_step: assert property (@(posedge clk) disable iff (rst)
    (adv && sec < 6'd59) |=> (sec == $past(sec) + 6'd1) && $stable(min));
  a_r7_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && sec == 6'd59 && min < 6'd59) |=> (sec == 6'd0) && (min == $past(min) + 6'd1));
  a_r7_hour_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && sec == 6'd59 && min == 6'd59 && hr == 5'd23) |=> (hr == 5'd0) && (min == 6'd0));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(sec) && $stable(min) && $stable(hr));
endmodule

// File: rtl/cal_date_core.sv
module cal_date_core
  import cal_pkg::*;
#(
  parameter int YEAR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              load,
  input  logic [4:0]        load_day,
  input  logic [3:0]        load_mon,
  input  logic [YEAR_W-1:0] load_year,
  input  logic              load_leap,
  output logic [4:0]        day,
  output logic [3:0]        mon,
  output logic [YEAR_W-1:0] year,
  output logic              leap
);
  localparam logic [YEAR_W-1:0] YEAR_ONE = YEAR_W'(1);

  logic last_day, last_mon, step;

  assign last_day = (day >= days_in_month(mon, leap));
  assign last_mon = (mon >= 4'd12);
  assign step     = adv && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      day  <= 5'd1;
      mon  <= 4'd1;
      year <= '0;
      leap <= 1'b0;
    end else if (load) begin
      day  <= load_day;
      mon  <= load_mon;
      year <= load_year;
      leap <= load_leap;
    end else if (adv) begin
      if (!last_day) begin
        day <= day + 5'd1;
      end else begin
        day <= 5'd1;
        if (last_mon) begin
          mon  <= 4'd1;
          year <= year + YEAR_ONE;
        end else begin
          mon <= mon + 4'd1;
        end
      end
    end
  end

  a_r8_feb_plain: assert property (@(posedge clk) disable iff (rst)
    (step && mon == 4'd2 && day == 5'd28 && !leap) |=> (day == 5'd1) && (mon == 4'd3));
  a_r8_feb_leap: assert property (@(posedge clk) disable iff (rst)
    (step && mon == 4'd2 && day == 5'd28 && leap) |=> (day == 5'd29) && (mon == 4'd2));
  a_r9_year_step: assert property (@(posedge clk) disable iff (rst)
    (step && mon == 4'd12 && day == 5'd31) |=> (mon == 4'd1) && (year == $past(year) + YEAR_ONE));
  a_r9_leap_kept: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(leap));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int COMMIT_CYCLES = 6,
  parameter bit WIDE_YEAR     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int YEAR_W   = WIDE_YEAR ? 8 : 6;
  localparam int LEAP_POS = WIDE_YEAR ? 24 : 22;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);

  logic        we_time, we_date;
  logic [31:0] time_stage, date_stage;
  logic        time_busy, date_busy, time_commit, date_commit;
  logic [5:0]  sec, min;
  logic [4:0]  hr, day;
  logic [3:0]  mon;
  logic [YEAR_W-1:0] year;
  logic        leap, day_carry;
  logic [31:0] time_word, date_word, ctrl_word;
  logic        unused_stage_bits;

  assign we_time = bus_we && (bus_addr == A_TIME);
  assign we_date = bus_we && (bus_addr == A_DATE);
  assign unused_stage_bits = ^{time_stage, date_stage};

  cal_commit_stage #(.W(32), .DELAY(COMMIT_CYCLES)) u_time_stage (
    .clk(clk), .rst(rst), .wr(we_time), .wdata(bus_wdata),
    .data(time_stage), .busy(time_busy), .commit(time_commit)
  );

  cal_commit_stage #(.W(32), .DELAY(COMMIT_CYCLES)) u_date_stage (
    .clk(clk), .rst(rst), .wr(we_date), .wdata(bus_wdata),
    .data(date_stage), .busy(date_busy), .commit(date_commit)
  );

  cal_time_core u_time (
    .clk(clk), .rst(rst), .tick(sec_tick), .load(time_commit),
    .load_sec(time_stage[SEC_LSB +: 6]),
    .load_min(time_stage[MIN_LSB +: 6]),
    .load_hr(time_stage[HR_LSB +: 5]),
    .sec(sec), .min(min), .hr(hr), .day_carry(day_carry)
  );

  cal_date_core #(.YEAR_W(YEAR_W)) u_date (
    .clk(clk), .rst(rst), .adv(day_carry), .load(date_commit),
    .load_day(date_stage[DAY_LSB +: 5]),
    .load_mon(date_stage[MON_LSB +: 4]),
    .load_year(date_stage[YEAR_LSB +: YEAR_W]),
    .load_leap(date_stage[LEAP_POS]),
    .day(day), .mon(mon), .year(year), .leap(leap)
  );

  always_comb begin
    time_word = '0;
    time_word[SEC_LSB +: 6] = sec;
    time_word[MIN_LSB +: 6] = min;
    time_word[HR_LSB +: 5]  = hr;
    date_word = '0;
    date_word[DAY_LSB +: 5]       = day;
    date_word[MON_LSB +: 4]       = mon;
    date_word[YEAR_LSB +: YEAR_W] = year;
    date_word[LEAP_POS]           = leap;
    ctrl_word = '0;
    ctrl_word[CTRL_TIME_BUSY] = time_busy;
    ctrl_word[CTRL_DATE_BUSY] = date_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_word;
        A_DATE:  bus_rdata <= date_word;
        A_TIME:  bus_rdata <= time_word;
        default: bus_rdata <= '0;
      endcase
    end
  end

  a_r11_ctrl_shape: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_CTRL) |=> ((bus_rdata & ~32'h0000_0180) == 32'h0));
  a_r4_pending_time_hold: assert property (@(posedge clk) disable iff (rst)
    (time_busy && !time_commit && !sec_tick) |=> $stable(sec) && $stable(min) && $stable(hr));
  a_r4_pending_date_hold: assert property (@(posedge clk) disable iff (rst)
    (date_busy && !date_commit && !day_carry) |=> $stable(day) && $stable(mon) && $stable(year));
  a_r11_ctrl_write_inert: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CTRL && !time_busy && !date_busy) |=> !time_busy && !date_busy);
endmodule

// File: tb/test_cal_clock.sv
`timescale 1ns/1ps
module test_cal_clock;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [3:0]  n_addr = '0, w_addr = '0;
  logic        n_we = 1'b0, w_we = 1'b0;
  logic [31:0] n_wdata = '0, w_wdata = '0;
  logic [31:0] n_rdata, w_rdata;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cal_clock #(.ADDR_W(4), .COMMIT_CYCLES(N), .WIDE_YEAR(1'b0)) i_cal_clock (
    .clk(clk), .rst(rst), .sec_tick(tick), .bus_addr(n_addr),
    .bus_we(n_we), .bus_wdata(n_wdata), .bus_rdata(n_rdata)
  );

  cal_clock #(.ADDR_W(4), .COMMIT_CYCLES(N), .WIDE_YEAR(1'b1)) i_cal_clock_wide (
    .clk(clk), .rst(rst), .sec_tick(tick), .bus_addr(w_addr),
    .bus_we(w_we), .bus_wdata(w_wdata), .bus_rdata(w_rdata)
  );

  function automatic logic [31:0] mk_t(int h, int m, int s);
    return 32'((h << 16) | (m << 8) | s);
  endfunction

  function automatic logic [31:0] mk_d(int d, int mo, int y, int lp);
    return 32'(d | (mo << 8) | (y << 16) | (lp << 22));
  endfunction

  // {start time, start date, expected time, expected date, requirement}
  localparam int NV = 12;
  localparam logic [135:0] VEC [NV] = '{
    {mk_t(0,0,58),   mk_d(5,3,3,0),   mk_t(0,0,59),  mk_d(5,3,3,0),  8'd7}, // R7
    {mk_t(0,0,59),   mk_d(5,3,3,0),   mk_t(0,1,0),   mk_d(5,3,3,0),  8'd7}, // R7
    {mk_t(0,59,59),  mk_d(5,3,3,0),   mk_t(1,0,0),   mk_d(5,3,3,0),  8'd7}, // R7
    {mk_t(23,59,59), mk_d(5,3,3,0),   mk_t(0,0,0),   mk_d(6,3,3,0),  8'd7}, // R7
    {mk_t(12,34,56), mk_d(9,9,9,0),   mk_t(12,34,57),mk_d(9,9,9,0),  8'd7}, // R7
    {mk_t(23,59,59), mk_d(30,4,1,0),  mk_t(0,0,0),   mk_d(1,5,1,0),  8'd8}, // R8
    {mk_t(23,59,59), mk_d(30,1,1,0),  mk_t(0,0,0),   mk_d(31,1,1,0), 8'd8}, // R8
    {mk_t(23,59,59), mk_d(28,2,2,0),  mk_t(0,0,0),   mk_d(1,3,2,0),  8'd8}, // R8
    {mk_t(23,59,59), mk_d(28,2,2,1),  mk_t(0,0,0),   mk_d(29,2,2,1), 8'd8}, // R8
    {mk_t(23,59,59), mk_d(29,2,2,1),  mk_t(0,0,0),   mk_d(1,3,2,1),  8'd8}, // R8
    {mk_t(23,59,59), mk_d(31,12,5,0), mk_t(0,0,0),   mk_d(1,1,6,0),  8'd9}, // R9
    {mk_t(23,59,59), mk_d(31,12,63,1),mk_t(0,0,0),   mk_d(1,1,0,1),  8'd9}  // R9
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  // One cycle each; called and returning at a falling edge.
  task automatic wr(input bit wide, input logic [3:0] a, input logic [31:0] d);
    if (wide) begin w_addr = a; w_wdata = d; w_we = 1'b1; end
    else      begin n_addr = a; n_wdata = d; n_we = 1'b1; end
    @(posedge clk); @(negedge clk);
    n_we = 1'b0; w_we = 1'b0;
  endtask

  task automatic rd(input bit wide, input logic [3:0] a, output logic [31:0] d);
    if (wide) w_addr = a; else n_addr = a;
    @(posedge clk); @(negedge clk);
    d = wide ? w_rdata : n_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 4'h0, v); check("R1 ctrl", v, 32'h0);
    rd(0, 4'h8, v); check("R1 time", v, 32'h0);
    rd(0, 4'h4, v); check("R1 date", v, 32'h0000_0101);

    // R2 + R4: time write busy window
    wr(0, 4'h8, 32'h000A_0B0C);
    rd(0, 4'h8, v); check("R4 time old while pending", v, 32'h0);
    for (int i = 0; i < N - 1; i++) begin
      rd(0, 4'h0, v); check("R2 time busy bit", v, 32'h0000_0100);
    end
    rd(0, 4'h0, v); check("R2 time busy cleared", v, 32'h0);
    rd(0, 4'h8, v); check("R2 time committed", v, 32'h000A_0B0C);

    // R3 + R4: date write busy window
    wr(0, 4'h4, 32'h0005_0A0F);
    rd(0, 4'h4, v); check("R4 date old while pending", v, 32'h0000_0101);
    for (int i = 0; i < N - 1; i++) begin
      rd(0, 4'h0, v); check("R3 date busy bit", v, 32'h0000_0080);
    end
    rd(0, 4'h0, v); check("R3 date busy cleared", v, 32'h0);
    rd(0, 4'h4, v); check("R3 date committed", v, 32'h0005_0A0F);

    // R5: rewrite while pending restarts with newest data
    wr(0, 4'h8, 32'h0001_0203);
    rd(0, 4'h0, v); rd(0, 4'h0, v);
    wr(0, 4'h8, 32'h0004_0506);
    for (int i = 0; i < 4; i++) begin
      rd(0, 4'h8, v); check("R5 stale data never lands", v, 32'h000A_0B0C);
    end
    for (int i = 0; i < N - 4; i++) begin
      rd(0, 4'h0, v); check("R5 busy extended", v, 32'h0000_0100);
    end
    rd(0, 4'h0, v); check("R5 busy cleared", v, 32'h0);
    rd(0, 4'h8, v); check("R5 newest data", v, 32'h0004_0506);

    // R6: zero writes then values, back to back
    wr(0, 4'h8, 32'h0); wr(0, 4'h4, 32'h0);
    wr(0, 4'h8, 32'h0011_2233); wr(0, 4'h4, 32'h0007_0314);
    rd(0, 4'h0, v); check("R6 both busy", v, 32'h0000_0180);
    idle(N + 1);
    rd(0, 4'h8, v); check("R6 final time", v, 32'h0011_2233);
    rd(0, 4'h4, v); check("R6 final date", v, 32'h0007_0314);

    // R11: control and unmapped writes are inert
    wr(0, 4'h0, 32'hFFFF_FFFF);
    wr(0, 4'hC, 32'h1234_5678);
    rd(0, 4'h0, v); check("R11 ctrl unchanged", v, 32'h0);
    rd(0, 4'h8, v); check("R11 time unchanged", v, 32'h0011_2233);
    rd(0, 4'h4, v); check("R11 date unchanged", v, 32'h0007_0314);
    rd(0, 4'hC, v); check("R11 unmapped reads zero", v, 32'h0);

    // R7, R8, R9: rollover table
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k][7:0], k);
      wr(0, 4'h8, VEC[k][135:104]);
      wr(0, 4'h4, VEC[k][103:72]);
      idle(N + 1);
      pulse_tick();
      rd(0, 4'h8, v); check({tag, " time"}, v, VEC[k][71:40]);
      rd(0, 4'h4, v); check({tag, " date"}, v, VEC[k][39:8]);
    end

    // R10: wide year layout, 8-bit year at [23:16], leap at bit 24
    wr(1, 4'h4, 32'h01C8_0709);
    idle(N + 1);
    rd(1, 4'h4, v); check("R10 wide date readback", v, 32'h01C8_0709);
    wr(1, 4'h8, mk_t(23,59,59));
    wr(1, 4'h4, 32'h01C8_0C1F);
    idle(N + 1);
    pulse_tick();
    rd(1, 4'h4, v); check("R10 wide year step", v, 32'h01C9_0101);
    wr(1, 4'h8, mk_t(23,59,59));
    wr(1, 4'h4, 32'h00FF_0C1F);
    idle(N + 1);
    pulse_tick();
    rd(1, 4'h4, v); check("R10 wide year wrap", v, 32'h0000_0101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule